// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits behind a 32-bit host write port and in front of a register file whose control registers are 128 bits wide. The host can only send one dword at a time, so the block gathers the dwords of a wide register in a single collector. It issues one commit strobe carrying the whole 128-bit value once every dword of that register has arrived. A memory window, selected by the top address bit, holds 64-bit words and is gathered the same way from two dwords.

Per-queue registers repeat every 0x2000 bytes: the page number sits above address bit 13 and the in-page offset below it. Two descriptor doorbells, at offsets 0x830 and 0xA10, do not need a full set of dwords. A write to the top dword of a doorbell always commits, with zeros in any lower lane the collector does not hold for it. Two 32-bit registers, at offsets 0x400 and 0x420, bypass the collector and appear on a separate direct strobe. A write to the 0x420 register in page 0 can also empty the collector. This behaviour is set by a parameter and is on by default.

The write port accepts one dword per cycle. Commit and direct strobes are registered and appear one cycle after the accepting edge.

Top module: `wide_wr_collector`

## Requirements
- R1: After reset, `commit_valid` and `direct_valid` are low, `drop_count` is zero and `in_ready` is high.
- R2: Once all four dwords of a wide register have been accepted, in any order, a one-cycle commit follows. It carries the 16-byte-aligned address and the data, with byte offset +0 in bits 31:0, +4 in 63:32, +8 in 95:64 and +12 in 127:96.
- R3: An address with bit 23 set (default width) is a 64-bit memory word. Its two dwords at +0 and +4 commit together at the 8-byte-aligned address, with bits 127:64 zero.
- R4: A wide-register or memory write to a different target while the collector is partly filled restarts the collector on the new target. The earlier lanes are lost, and `drop_count` increments by one (wrapping).
- R5: A write at doorbell offset +12 (in-page 0x83C or 0xA1C) always commits on the next cycle. Lanes that the collector does not hold for that doorbell are committed as zero.
- R6: A write to a lower dword of a doorbell, while the collector holds lanes of another target, is discarded. The collector and `drop_count` are unchanged.
- R7: A write at in-page offset 0x400 or 0x420 produces, on the next cycle, a one-cycle `direct_valid` with the full address and data. Apart from R8, it leaves the collector untouched, and it never coincides with a commit.
- R8: With `TIMER_QUIRK` set, a direct write at offset 0x420 in page 0 empties the collector without a commit. The same write in any other page does not.
- R9: Offsets are decoded within each 0x2000-byte page, so the register kinds behave the same in every page.
- R10: After a commit the collector is empty. A later partial write sequence to the same register does not commit until it is again complete.
- R11: Writing the same dword twice before completion keeps the later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host dword write present |
| in_ready | output | 1 | Block accepts a dword this cycle |
| in_addr | input | ADDR_W | Byte address of the dword |
| in_data | input | 32 | Dword value |
| commit_valid | output | 1 | One-cycle wide-register commit strobe |
| commit_addr | output | ADDR_W | Aligned address of the committed register |
| commit_data | output | 128 | Committed value |
| direct_valid | output | 1 | One-cycle strobe for a 32-bit register write |
| direct_addr | output | ADDR_W | Address of the 32-bit register |
| direct_data | output | 32 | Value of the 32-bit register |
| drop_count | output | CNT_W | Count of partial values lost to a restart |

## Verification
The bench targets lanes arriving out of order and dwords rewritten before completion. A collector that counted writes instead of tracking lanes would commit early or with stale data. Doorbell top writes are sent alone, after matching lower lanes and after foreign partial data. A wrong design would either withhold the commit, leak lanes from another register into it, or destroy the foreign data. Timer-register writes in page 0 and in page 1 separate a quirk applied in every page from one applied nowhere, and interleaved targets check that each restart increments the drop count exactly once.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
    localparam int DW       = 32;
    localparam int LANES    = 4;
    localparam int OFF_W    = 13;
    localparam logic [OFF_W-1:0] OFF_EVQ_PTR = 13'h400;
    localparam logic [OFF_W-1:0] OFF_TIMER   = 13'h420;
    localparam logic [OFF_W-1:0] OFF_RX_DB   = 13'h830;
    localparam logic [OFF_W-1:0] OFF_TX_DB   = 13'hA10;

    typedef enum logic [1:0] {
        KIND_WIDE   = 2'd0,
        KIND_MEM    = 2'd1,
        KIND_DOOR   = 2'd2,
        KIND_DIRECT = 2'd3
    } wkind_e;

    typedef logic [DW-1:0]           dword_t;
    typedef dword_t [LANES-1:0]      lanes_t;

    function automatic logic in_doorbell(input logic [OFF_W-1:0] off);
        return (off[OFF_W-1:4] == OFF_RX_DB[OFF_W-1:4]) ||
               (off[OFF_W-1:4] == OFF_TX_DB[OFF_W-1:4]);
    endfunction
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output wkind_e            kind,
    output logic [ADDR_W-1:0] base,
    output logic [1:0]        lane,
    output logic              timer_pg0
);
    localparam int PAGE_W = ADDR_W - 1 - OFF_W;

    logic                 is_mem;
    logic [OFF_W-1:0]     off;
    logic [PAGE_W-1:0]    page;

    assign is_mem = addr[ADDR_W-1];
    assign off    = addr[OFF_W-1:0];
    assign page   = addr[ADDR_W-2:OFF_W];

    always_comb begin
        if (is_mem) begin
            kind = KIND_MEM;
        end else if (off == OFF_EVQ_PTR || off == OFF_TIMER) begin
            kind = KIND_DIRECT;
        end else if (in_doorbell(off)) begin
            kind = KIND_DOOR;
        end else begin
            kind = KIND_WIDE;
        end
    end

    always_comb begin
        if (is_mem) begin
            base = {addr[ADDR_W-1:3], 3'b000};
            lane = {1'b0, addr[2]};
        end else begin
            base = {addr[ADDR_W-1:4], 4'b0000};
            lane = addr[3:2];
        end
    end

    assign timer_pg0 = !is_mem && (off == OFF_TIMER) && (page == '0);
endmodule

// File: rtl/wwc_collect.sv
module wwc_collect
    import wwc_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int CNT_W       = 8,
    parameter bit TIMER_QUIRK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wkind_e            kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        lane,
    input  logic              timer_pg0,
    input  dword_t            wdata,
    output logic              cmt_valid,
    output logic [ADDR_W-1:0] cmt_addr,
    output lanes_t            cmt_data,
    output logic [CNT_W-1:0]  drop_cnt
);
    lanes_t              c_data, n_data, t_data, t_out;
    logic [LANES-1:0]    c_mask, n_mask, t_mask, lane_bit;
    logic [ADDR_W-1:0]   c_tag, n_tag;
    wkind_e              c_kind, n_kind;
    logic                holds, foreign, full, fire, bump;

    assign holds    = (|c_mask) && (c_tag == base) && (c_kind == kind);
    assign foreign  = (|c_mask) && !holds;
    assign lane_bit = LANES'(1) << lane;

    always_comb begin
        t_mask       = foreign ? lane_bit : (c_mask | lane_bit);
        t_data       = foreign ? '0 : c_data;
        t_data[lane] = wdata;
    end

    assign full = (kind == KIND_MEM) ? (&t_mask[1:0]) : (&t_mask);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_out
        assign t_out[g] = t_mask[g] ? t_data[g] : '0;
    end

    always_comb begin
        n_data = c_data;
        n_mask = c_mask;
        n_tag  = c_tag;
        n_kind = c_kind;
        fire   = 1'b0;
        bump   = 1'b0;
        if (wr_en) begin
            unique case (kind)
                KIND_DIRECT: begin
                    if (TIMER_QUIRK && timer_pg0) n_mask = '0;
                end
                KIND_WIDE, KIND_MEM: begin
                    n_data = t_data;
                    n_mask = t_mask;
                    n_tag  = base;
                    n_kind = kind;
                    bump   = foreign;
                    if (full) begin
                        fire   = 1'b1;
                        n_mask = '0;
                    end
                end
                KIND_DOOR: begin
                    if (lane == 2'd3) begin
                        fire = 1'b1;
                        if (!foreign) n_mask = '0;
                    end else if (!foreign) begin
                        n_data = t_data;
                        n_mask = t_mask;
                        n_tag  = base;
                        n_kind = kind;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_mask    <= '0;
            c_data    <= '0;
            c_tag     <= '0;
            c_kind    <= KIND_WIDE;
            cmt_valid <= 1'b0;
            cmt_addr  <= '0;
            cmt_data  <= '0;
            drop_cnt  <= '0;
        end else begin
            c_mask    <= n_mask;
            c_data    <= n_data;
            c_tag     <= n_tag;
            c_kind    <= n_kind;
            cmt_valid <= fire;
            if (fire) begin
                cmt_addr <= base;
                cmt_data <= t_out;
            end
            if (bump) drop_cnt <= drop_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wide_wr_collector.sv
module wide_wr_collector
    import wwc_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int CNT_W       = 8,
    parameter bit TIMER_QUIRK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [31:0]       in_data,
    output logic              commit_valid,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [127:0]      commit_data,
    output logic              direct_valid,
    output logic [ADDR_W-1:0] direct_addr,
    output logic [31:0]       direct_data,
    output logic [CNT_W-1:0]  drop_count
);
    wkind_e            kind;
    logic [ADDR_W-1:0] base;
    logic [1:0]        lane;
    logic              timer_pg0;
    logic              accept;
    lanes_t            cdata;

    assign in_ready = 1'b1;
    assign accept   = in_valid && in_ready;

    wwc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (in_addr),
        .kind      (kind),
        .base      (base),
        .lane      (lane),
        .timer_pg0 (timer_pg0)
    );

    wwc_collect #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TIMER_QUIRK(TIMER_QUIRK)) u_col (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept),
        .kind      (kind),
        .base      (base),
        .lane      (lane),
        .timer_pg0 (timer_pg0),
        .wdata     (in_data),
        .cmt_valid (commit_valid),
        .cmt_addr  (commit_addr),
        .cmt_data  (cdata),
        .drop_cnt  (drop_count)
    );

    assign commit_data = cdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            direct_valid <= 1'b0;
            direct_addr  <= '0;
            direct_data  <= '0;
        end else begin
            direct_valid <= accept && (kind == KIND_DIRECT);
            if (accept && kind == KIND_DIRECT) begin
                direct_addr <= in_addr;
                direct_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/wwc_checker.sv
module wwc_checker #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_addr,
    input logic              commit_valid,
    input logic              direct_valid,
    input logic [CNT_W-1:0]  drop_count
);
    logic door_top;
    assign door_top = !in_addr[ADDR_W-1] &&
                      (in_addr[12:0] == 13'h83C || in_addr[12:0] == 13'hA1C);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!commit_valid && !direct_valid && drop_count == '0));

    assert_commit_cause_R2: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> $past(in_valid && in_ready));

    assert_drop_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (drop_count == $past(drop_count) ||
                         drop_count == CNT_W'($past(drop_count) + 1'b1)));

    assert_door_top_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && in_ready && door_top)) |-> commit_valid);

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({commit_valid, direct_valid}));

    assert_direct_cause_R7: assert property (@(posedge clk) disable iff (rst)
        direct_valid |-> $past(in_valid && in_ready));
endmodule

bind wide_wr_collector wwc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_addr      (in_addr),
    .commit_valid (commit_valid),
    .direct_valid (direct_valid),
    .drop_count   (drop_count)
);

// File: tb/tb_wide_wr_collector.sv
`timescale 1ns/1ps
module tb_wide_wr_collector;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [23:0]  in_addr = '0;
    logic [31:0]  in_data = '0;
    logic         commit_valid;
    logic [23:0]  commit_addr;
    logic [127:0] commit_data;
    logic         direct_valid;
    logic [23:0]  direct_addr;
    logic [31:0]  direct_data;
    logic [7:0]   drop_count;

    always #2.5 clk = ~clk;

    wide_wr_collector dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data),
        .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data),
        .direct_valid(direct_valid), .direct_addr(direct_addr), .direct_data(direct_data),
        .drop_count(drop_count)
    );

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model state
    bit [31:0]  m_lane [4];
    bit [3:0]   m_mask = '0;
    bit [23:0]  m_tag  = '0;
    int         m_kind = 0;
    bit         e_cv = 0, e_dv = 0;
    bit [23:0]  e_ca = '0, e_da = '0;
    bit [127:0] e_cd = '0;
    bit [31:0]  e_dd = '0;
    bit [7:0]   e_cnt = '0;

    function automatic bit [23:0] pa(input int page, input int off);
        return {1'b0, 10'(page), 13'(off)};
    endfunction

    task automatic model_step(input bit v, input bit [23:0] a, input bit [31:0] d);
        int knd, ln;
        bit [12:0] off;
        bit [23:0] base;
        bit match, other;
        bit [3:0] need;
        e_cv = 0;
        e_dv = 0;
        if (!v) return;
        off = a[12:0];
        if (a[23]) knd = 1;
        else if (off == 13'h400 || off == 13'h420) knd = 3;
        else if (off[12:4] == 9'h083 || off[12:4] == 9'h0A1) knd = 2;
        else knd = 0;
        if (knd == 3) begin
            e_dv = 1; e_da = a; e_dd = d;
            if (off == 13'h420 && a[22:13] == 0) m_mask = '0;
            return;
        end
        base  = (knd == 1) ? {a[23:3], 3'b0} : {a[23:4], 4'b0};
        ln    = (knd == 1) ? int'(a[2]) : int'(a[3:2]);
        match = (m_mask != 0) && (m_tag == base) && (m_kind == knd);
        other = (m_mask != 0) && !match;
        if (knd == 2 && ln == 3) begin
            e_cv = 1; e_ca = base;
            for (int i = 0; i < 3; i++)
                e_cd[i*32 +: 32] = (match && m_mask[i]) ? m_lane[i] : 32'h0;
            e_cd[127:96] = d;
            if (match) m_mask = '0;
            return;
        end
        if (knd == 2 && other) return;
        if (other) begin
            m_mask = '0;
            if (knd != 2) e_cnt = e_cnt + 1;
        end
        m_mask[ln] = 1'b1;
        m_lane[ln] = d;
        m_tag = base;
        m_kind = knd;
        need = (knd == 1) ? 4'b0011 : 4'b1111;
        if (knd != 2 && (m_mask & need) == need) begin
            e_cv = 1; e_ca = base;
            for (int i = 0; i < 4; i++)
                e_cd[i*32 +: 32] = m_mask[i] ? m_lane[i] : 32'h0;
            m_mask = '0;
        end
    endtask

    task automatic compare();
        checks++;
        if (commit_valid !== e_cv || (e_cv && (commit_addr !== e_ca || commit_data !== e_cd))) begin
            fails++;
            $display("FAIL %s commit: got v=%0b a=%h d=%h exp v=%0b a=%h d=%h",
                     tag, commit_valid, commit_addr, commit_data, e_cv, e_ca, e_cd);
        end
        checks++;
        if (direct_valid !== e_dv || (e_dv && (direct_addr !== e_da || direct_data !== e_dd))) begin
            fails++;
            $display("FAIL %s direct: got v=%0b a=%h d=%h exp v=%0b a=%h d=%h",
                     tag, direct_valid, direct_addr, direct_data, e_dv, e_da, e_dd);
        end
        checks++;
        if (drop_count !== e_cnt) begin
            fails++;
            $display("FAIL %s drop_count: got %0d exp %0d", tag, drop_count, e_cnt);
        end
    endtask

    task automatic step(input bit v, input bit [23:0] a, input bit [31:0] d);
        @(negedge clk);
        compare();
        in_valid = v;
        in_addr  = a;
        in_data  = d;
        model_step(v, a, d);
    endtask

    task automatic wr(input bit [23:0] a, input bit [31:0] d);
        step(1'b1, a, d);
    endtask

    task automatic idle();
        step(1'b0, '0, '0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 in_ready: got %0b exp 1", in_ready);
        end
        idle();

        // R2 and R9: out-of-order lanes in page 3
        tag = "R2";
        wr(pa(3, 'h108), 32'hC2C2_0002);
        wr(pa(3, 'h100), 32'hC0C0_0000);
        wr(pa(3, 'h10C), 32'hC3C3_0003);
        wr(pa(3, 'h104), 32'hC1C1_0001);
        idle();

        // R11: rewrite of one lane
        tag = "R11";
        wr(pa(0, 'h200), 32'h1111_1111);
        wr(pa(0, 'h200), 32'h2222_2222);
        wr(pa(0, 'h204), 32'h3);
        wr(pa(0, 'h208), 32'h4);
        wr(pa(0, 'h20C), 32'h5);
        idle();

        // R10: partial rewrite after a commit stays pending
        tag = "R10";
        wr(pa(0, 'h200), 32'hA);
        wr(pa(0, 'h204), 32'hB);
        wr(pa(0, 'h208), 32'hC);
        idle(); idle();

        // R4: a different target restarts and counts
        tag = "R4";
        wr(pa(1, 'h300), 32'hD0);
        wr(pa(1, 'h304), 32'hD1);
        wr(pa(1, 'h308), 32'hD2);
        wr(pa(1, 'h30C), 32'hD3);
        idle();

        // R3: memory word pair
        tag = "R3";
        wr(24'h80_0044, 32'hEEEE_0001);
        wr(24'h80_0040, 32'hEEEE_0000);
        idle();

        // R5: doorbell with lane 1 held, then top alone
        tag = "R5";
        wr(pa(5, 'h834), 32'h5151);
        wr(pa(5, 'h83C), 32'h5353);
        wr(pa(2, 'hA1C), 32'h7777);
        idle();

        // R6: foreign doorbell lower write discarded
        tag = "R6";
        wr(pa(4, 'h040), 32'h60);
        wr(pa(4, 'h044), 32'h61);
        wr(pa(4, 'hA10), 32'hBAD0);
        wr(pa(4, 'h048), 32'h62);
        wr(pa(4, 'h04C), 32'h63);
        idle();

        // R5 with foreign collector: commit zero-filled, foreign kept
        tag = "R5";
        wr(pa(6, 'h050), 32'h70);
        wr(pa(6, 'h83C), 32'h71);
        wr(pa(6, 'h054), 32'h72);
        wr(pa(6, 'h058), 32'h73);
        wr(pa(6, 'h05C), 32'h74);
        idle();

        // R7: direct writes leave the collector alone
        tag = "R7";
        wr(pa(2, 'h060), 32'h80);
        wr(pa(2, 'h400), 32'hABCD);
        wr(pa(2, 'h420), 32'h1234);
        wr(pa(2, 'h064), 32'h81);
        wr(pa(2, 'h068), 32'h82);
        wr(pa(2, 'h06C), 32'h83);
        idle();

        // R8: page-0 timer clears, page-1 timer does not
        tag = "R8";
        wr(pa(0, 'h070), 32'h90);
        wr(pa(0, 'h074), 32'h91);
        wr(pa(0, 'h420), 32'h5);
        wr(pa(0, 'h078), 32'h92);
        wr(pa(0, 'h07C), 32'h93);
        idle(); idle();
        wr(pa(7, 'h080), 32'hA0);
        wr(pa(7, 'h084), 32'hA1);
        wr(pa(1, 'h420), 32'h6);
        wr(pa(7, 'h088), 32'hA2);
        wr(pa(7, 'h08C), 32'hA3);
        idle();

        // R9: mixed stream across pages with gaps
        tag = "R9";
        for (int i = 0; i < 400; i++) begin
            int sel;
            bit [23:0] a;
            sel = int'($urandom_range(0, 7));
            case (sel)
                0, 1, 2: a = pa(int'($urandom_range(0, 1)), 'h100 + 4 * int'($urandom_range(0, 3)));
                3:       a = pa(int'($urandom_range(0, 1)), 'h830 + 4 * int'($urandom_range(0, 3)));
                4:       a = pa(int'($urandom_range(0, 1)), 'hA10 + 4 * int'($urandom_range(0, 3)));
                5:       a = pa(int'($urandom_range(0, 1)), $urandom_range(0, 1) ? 'h400 : 'h420);
                default: a = 24'h80_0000 + 4 * int'($urandom_range(0, 3));
            endcase
            step($urandom_range(0, 3) != 0, a, $urandom);
        end
        idle(); idle();
        finish_run();
    end
endmodule